// File: doc/BRIEF.md
# Snooping Cache-Line Coherence Controller

This block tracks the coherence state of every line of one private write-back cache in a small snooping multiprocessor. It keeps six states per line: Modified, Owned, Exclusive, Shared, Forward and Invalid. From the current state of a line it decides whether a local read or write can complete at once, or whether a bus request is needed. It also answers requests snooped from other caches by supplying data, dropping its copy or downgrading it.

Each line has a 3-bit state. The Owned state lets dirty data be shared without updating memory. The Forward state makes exactly one clean sharer the cache that supplies data. The block works in single-cycle steps. The outputs follow from the current state and the inputs of the same cycle, and the state changes at the next rising clock edge. The shared and dirty responses for a local miss arrive in the same cycle as the bus request.

The surrounding cache keeps the data and tags and does the arbitration. It gives a line index with each local request or snooped request. When a snooped request and a local request arrive in the same cycle, the local request is dropped and must be retried.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line reads as Invalid. The state codes are Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4 and Forward=5, shown on `state_o` for the line at `loc_idx_i`.
- R2: A local read (op 0) to a line that is not Invalid sets `hit_o`, issues no bus request and leaves the state unchanged.
- R3: A local read to an Invalid line issues a bus read (bus code 1) with `hit_o` low. The line fills as Exclusive when `shared_i` is low, as Shared when `shared_i` and `dirty_i` are both high, and as Forward when `shared_i` is high and `dirty_i` is low.
- R4: A local write (op 1) sets `hit_o` with no bus request only in Modified or Exclusive. A write in Exclusive moves the line to Modified, and a write in Modified keeps it there.
- R5: A local write to a Shared or Invalid line issues a read-for-ownership (bus code 2) with `hit_o` low, and the line becomes Modified.
- R6: A local write to an Owned or Forward line issues an upgrade (bus code 3) with `hit_o` low, and the line becomes Modified.
- R7: A snooped read (snoop op 0) has the following effects. Modified moves to Owned and supplies data. Owned stays Owned and supplies data. Forward moves to Shared and supplies data. Exclusive moves to Shared without supplying. Shared and Invalid do not change and supply nothing.
- R8: A snooped read-for-ownership (snoop op 1) sends the line to Invalid. `supply_o` is set when the line was Modified, Owned or Forward.
- R9: A snooped upgrade (snoop op 2) sends the line to Invalid and never sets `supply_o`.
- R10: A local eviction (op 2) sends the line to Invalid. It sets `writeback_o` only when the line was Modified or Owned.
- R11: While `snp_valid_i` is high, the local request is ignored: `hit_o`, `bus_req_o` and `writeback_o` stay low, and the local line does not change unless the snoop targets it.
- R12: Each event changes only the line it addresses. Local op 3 and snoop op 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_valid_i | input | 1 | Local request present |
| loc_op_i | input | 2 | Local op: 0 read, 1 write, 2 evict, 3 none |
| loc_idx_i | input | IDX_W | Line index of the local request |
| snp_valid_i | input | 1 | Snooped request present |
| snp_op_i | input | 2 | Snoop op: 0 read, 1 read-for-ownership, 2 upgrade, 3 none |
| snp_idx_i | input | IDX_W | Line index of the snooped request |
| shared_i | input | 1 | Another cache holds the line being fetched |
| dirty_i | input | 1 | The data for the fetch comes from a dirty holder |
| bus_req_o | output | 2 | Bus request: 0 none, 1 read, 2 read-for-ownership, 3 upgrade |
| supply_o | output | 1 | This cache supplies data to the snooped request |
| writeback_o | output | 1 | Dirty line must be written back on eviction |
| hit_o | output | 1 | Local request completes without the bus |
| state_o | output | 3 | Current state of the line at loc_idx_i |

## Verification
Directed sequences take a single line through every transition. A read miss is filled in each of its three ways, and each resulting state is then observed through a hit, a write upgrade, a snooped read, a snooped read-for-ownership and a snooped upgrade. These sequences separate the dirty sharing path (Modified to Owned) from the clean forwarding path (Forward to Shared). A same-cycle collision of a snoop and a local request shows whether the snoop really takes priority. A long seeded random run mixes all ops, including the no-op codes, over every line index. A reference model checks that events never leak onto other lines and that states reached only through long sequences still behave correctly.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4, ST_F = 3'd5
  } line_st_e;

  typedef enum logic [1:0] {
    LOC_RD = 2'd0, LOC_WR = 2'd1, LOC_EVICT = 2'd2, LOC_NOP = 2'd3
  } loc_op_e;

  typedef enum logic [1:0] {
    SNP_RD = 2'd0, SNP_RFO = 2'd1, SNP_UPG = 2'd2, SNP_NOP = 2'd3
  } snp_op_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0, BUS_RD = 2'd1, BUS_RFO = 2'd2, BUS_UPG = 2'd3
  } bus_op_e;

  localparam int unsigned ST_W = 3;
endpackage

// File: rtl/coh_state_array.sv
`timescale 1ns/1ps
module coh_state_array
  import coh_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  line_st_e         wdata_i,
  input  logic [IDX_W-1:0] ridx_a_i,
  output line_st_e         rdata_a_o,
  input  logic [IDX_W-1:0] ridx_b_i,
  output line_st_e         rdata_b_o
);
  line_st_e st_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g] <= ST_I;
      end else if (we_i && widx_i == IDX_W'(g)) begin
        st_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = st_q[ridx_a_i];
  assign rdata_b_o = st_q[ridx_b_i];
endmodule

// File: rtl/coh_local_fsm.sv
`timescale 1ns/1ps
module coh_local_fsm
  import coh_pkg::*;
(
  input  line_st_e cur_i,
  input  loc_op_e  op_i,
  input  logic     shared_i,
  input  logic     dirty_i,
  output line_st_e nxt_o,
  output logic     upd_o,
  output logic     hit_o,
  output bus_op_e  bus_o,
  output logic     wb_o
);
  always_comb begin
    nxt_o = cur_i;
    upd_o = 1'b0;
    hit_o = 1'b0;
    bus_o = BUS_NONE;
    wb_o  = 1'b0;
    unique case (op_i)
      LOC_RD: begin
        if (cur_i != ST_I) begin
          hit_o = 1'b1;
        end else begin
          bus_o = BUS_RD;
          upd_o = 1'b1;
          // fill state chosen from the snoop responses seen with the fetch
          if (!shared_i)    nxt_o = ST_E;
          else if (dirty_i) nxt_o = ST_S;
          else              nxt_o = ST_F;
        end
      end
      LOC_WR: begin
        unique case (cur_i)
          ST_M: hit_o = 1'b1;
          ST_E: begin
            hit_o = 1'b1;
            nxt_o = ST_M;
            upd_o = 1'b1;
          end
          ST_O, ST_F: begin
            bus_o = BUS_UPG;
            nxt_o = ST_M;
            upd_o = 1'b1;
          end
          default: begin
            bus_o = BUS_RFO;
            nxt_o = ST_M;
            upd_o = 1'b1;
          end
        endcase
      end
      LOC_EVICT: begin
        if (cur_i != ST_I) begin
          nxt_o = ST_I;
          upd_o = 1'b1;
        end
        wb_o = (cur_i == ST_M) || (cur_i == ST_O);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_snoop_fsm.sv
`timescale 1ns/1ps
module coh_snoop_fsm
  import coh_pkg::*;
(
  input  line_st_e cur_i,
  input  snp_op_e  op_i,
  output line_st_e nxt_o,
  output logic     upd_o,
  output logic     supply_o
);
  always_comb begin
    nxt_o    = cur_i;
    upd_o    = 1'b0;
    supply_o = 1'b0;
    unique case (op_i)
      SNP_RD: begin
        unique case (cur_i)
          ST_M: begin
            nxt_o    = ST_O;
            upd_o    = 1'b1;
            supply_o = 1'b1;
          end
          ST_O: supply_o = 1'b1;
          ST_F: begin
            nxt_o    = ST_S;
            upd_o    = 1'b1;
            supply_o = 1'b1;
          end
          ST_E: begin
            nxt_o = ST_S;
            upd_o = 1'b1;
          end
          default: ;
        endcase
      end
      SNP_RFO: begin
        nxt_o    = ST_I;
        upd_o    = 1'b1;
        supply_o = (cur_i == ST_M) || (cur_i == ST_O) || (cur_i == ST_F);
      end
      SNP_UPG: begin
        nxt_o = ST_I;
        upd_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_line_ctrl.sv
`timescale 1ns/1ps
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loc_valid_i,
  input  logic [1:0]       loc_op_i,
  input  logic [IDX_W-1:0] loc_idx_i,
  input  logic             snp_valid_i,
  input  logic [1:0]       snp_op_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic             shared_i,
  input  logic             dirty_i,
  output logic [1:0]       bus_req_o,
  output logic             supply_o,
  output logic             writeback_o,
  output logic             hit_o,
  output logic [ST_W-1:0]  state_o
);
  line_st_e loc_cur, snp_cur, loc_nxt, snp_nxt, wr_st;
  logic     loc_upd, snp_upd, loc_hit, loc_wb, snp_sup;
  bus_op_e  loc_bus;
  logic     loc_go, wr_en;
  logic [IDX_W-1:0] wr_idx;

  coh_state_array #(.NUM_LINES(NUM_LINES)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en),
    .widx_i   (wr_idx),
    .wdata_i  (wr_st),
    .ridx_a_i (loc_idx_i),
    .rdata_a_o(loc_cur),
    .ridx_b_i (snp_idx_i),
    .rdata_b_o(snp_cur)
  );

  coh_local_fsm u_local (
    .cur_i   (loc_cur),
    .op_i    (loc_op_e'(loc_op_i)),
    .shared_i(shared_i),
    .dirty_i (dirty_i),
    .nxt_o   (loc_nxt),
    .upd_o   (loc_upd),
    .hit_o   (loc_hit),
    .bus_o   (loc_bus),
    .wb_o    (loc_wb)
  );

  coh_snoop_fsm u_snoop (
    .cur_i   (snp_cur),
    .op_i    (snp_op_e'(snp_op_i)),
    .nxt_o   (snp_nxt),
    .upd_o   (snp_upd),
    .supply_o(snp_sup)
  );

  // snoop wins; the local requester retries
  assign loc_go = loc_valid_i && !snp_valid_i;

  always_comb begin
    if (snp_valid_i) begin
      wr_en  = snp_upd;
      wr_idx = snp_idx_i;
      wr_st  = snp_nxt;
    end else begin
      wr_en  = loc_valid_i && loc_upd;
      wr_idx = loc_idx_i;
      wr_st  = loc_nxt;
    end
  end

  assign bus_req_o   = loc_go ? loc_bus : BUS_NONE;
  assign hit_o       = loc_go && loc_hit;
  assign writeback_o = loc_go && loc_wb;
  assign supply_o    = snp_valid_i && snp_sup;
  assign state_o     = loc_cur;
endmodule

// File: rtl/coh_line_ctrl_chk.sv
`timescale 1ns/1ps
module coh_line_ctrl_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             loc_valid_i,
  input logic [1:0]       loc_op_i,
  input logic [IDX_W-1:0] loc_idx_i,
  input logic             snp_valid_i,
  input logic [1:0]       snp_op_i,
  input logic [IDX_W-1:0] snp_idx_i,
  input logic             shared_i,
  input logic             dirty_i,
  input logic [1:0]       bus_req_o,
  input logic             supply_o,
  input logic             writeback_o,
  input logic             hit_o,
  input logic [2:0]       state_o
);
  logic loc_go;
  assign loc_go = loc_valid_i && !snp_valid_i;

  a_r2_read_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_go && loc_op_i == 2'd0 && state_o != 3'd0) |-> (hit_o && bus_req_o == 2'd0));

  a_r3_hit_excludes_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, bus_req_o != 2'd0}));

  a_r4_excl_write_dirties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_go && loc_op_i == 2'd1 && state_o == 3'd2 && !snp_valid_i)
    |=> (loc_idx_i != $past(loc_idx_i) || snp_valid_i || state_o == 3'd4));

  a_r5_shared_write_rfo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_go && loc_op_i == 2'd1 && (state_o == 3'd1 || state_o == 3'd0)) |-> bus_req_o == 2'd2);

  a_r9_r7_supply_needs_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_o |-> (snp_valid_i && snp_op_i != 2'd2 && snp_op_i != 2'd3));

  a_r10_wb_from_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    writeback_o |-> (loc_op_i == 2'd2 && (state_o == 3'd4 || state_o == 3'd3)));

  a_r11_snoop_blocks_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> (!hit_o && bus_req_o == 2'd0 && !writeback_o));

  a_r1_state_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5);
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/coh_line_ctrl_tb.sv
`timescale 1ns/1ps
module coh_line_ctrl_tb;
  localparam int NL = 8;
  localparam int IW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          loc_valid_i = 1'b0;
  logic [1:0]    loc_op_i = 2'd3;
  logic [IW-1:0] loc_idx_i = '0;
  logic          snp_valid_i = 1'b0;
  logic [1:0]    snp_op_i = 2'd3;
  logic [IW-1:0] snp_idx_i = '0;
  logic          shared_i = 1'b0;
  logic          dirty_i = 1'b0;
  logic [1:0]    bus_req_o;
  logic          supply_o, writeback_o, hit_o;
  logic [2:0]    state_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] mdl [NL];

  always #4 clk_i = ~clk_i;

  coh_line_ctrl #(.NUM_LINES(NL)) u_dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // Reference: local transition (codes I0 S1 E2 O3 M4 F5)
  task automatic ref_local(input logic [2:0] s, input logic [1:0] op, input logic sh,
                           input logic dy, output logic [2:0] n, output logic h,
                           output logic [1:0] b, output logic w);
    n = s; h = 0; b = 0; w = 0;
    case (op)
      2'd0: if (s != 0) h = 1; else begin b = 1; n = !sh ? 3'd2 : (dy ? 3'd1 : 3'd5); end
      2'd1: begin
        if (s == 4 || s == 2) h = 1;
        else if (s == 3 || s == 5) b = 3;
        else b = 2;
        n = 3'd4;
      end
      2'd2: begin w = (s == 4 || s == 3); n = 3'd0; end
      default: ;
    endcase
  endtask

  task automatic ref_snoop(input logic [2:0] s, input logic [1:0] op,
                           output logic [2:0] n, output logic sp);
    n = s; sp = 0;
    case (op)
      2'd0: case (s)
        3'd4: begin n = 3; sp = 1; end
        3'd3: sp = 1;
        3'd5: begin n = 1; sp = 1; end
        3'd2: n = 1;
        default: ;
      endcase
      2'd1: begin sp = (s == 4 || s == 3 || s == 5); n = 0; end
      2'd2: n = 0;
      default: ;
    endcase
  endtask

  task automatic step(input string tag, input logic lv, input logic [1:0] lop,
                      input logic [IW-1:0] li, input logic sv, input logic [1:0] sop,
                      input logic [IW-1:0] si, input logic sh, input logic dy);
    logic [2:0] n; logic h, w, sp; logic [1:0] b;
    @(negedge clk_i);
    loc_valid_i = lv; loc_op_i = lop; loc_idx_i = li;
    snp_valid_i = sv; snp_op_i = sop; snp_idx_i = si;
    shared_i = sh; dirty_i = dy;
    #2;
    chk(tag, "state_o", state_o, mdl[li]);
    if (sv) begin
      ref_snoop(mdl[si], sop, n, sp);
      chk(tag, "supply_o", supply_o, sp);
      chk(tag, "hit_o", hit_o, 0);
      chk(tag, "bus_req_o", bus_req_o, 0);
      chk(tag, "writeback_o", writeback_o, 0);
      mdl[si] = n;
    end else begin
      chk(tag, "supply_o", supply_o, 0);
      if (lv) begin
        ref_local(mdl[li], lop, sh, dy, n, h, b, w);
        mdl[li] = n;
      end else begin
        h = 0; b = 0; w = 0;
      end
      chk(tag, "hit_o", hit_o, h);
      chk(tag, "bus_req_o", bus_req_o, b);
      chk(tag, "writeback_o", writeback_o, w);
    end
  endtask

  task automatic peek(input string tag, input logic [IW-1:0] li, input int exp);
    @(negedge clk_i);
    loc_valid_i = 0; snp_valid_i = 0; loc_idx_i = li;
    #2;
    chk(tag, "state_o", state_o, exp);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NL; i++) mdl[i] = 3'd0;
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NL; i++) peek("R1", IW'(i), 0);

    step("R3", 1, 0, 0, 0, 0, 0, 0, 0);   // miss, fill E
    peek("R3", 0, 2);
    step("R2", 1, 0, 0, 0, 0, 0, 1, 1);   // read hit in E
    step("R4", 1, 1, 0, 0, 0, 0, 0, 0);   // E write -> M
    peek("R4", 0, 4);
    step("R4", 1, 1, 0, 0, 0, 0, 0, 0);   // M write hit
    step("R7", 0, 0, 0, 1, 0, 0, 0, 0);   // snoop read M -> O, supply
    peek("R7", 0, 3);
    step("R7", 0, 0, 0, 1, 0, 0, 0, 0);   // O stays, supply
    step("R11", 1, 0, 1, 1, 0, 0, 0, 0);  // local to line 1 dropped
    peek("R11", 1, 0);
    step("R6", 1, 1, 0, 0, 0, 0, 0, 0);   // O write -> upgrade
    peek("R6", 0, 4);
    step("R10", 1, 2, 0, 0, 0, 0, 0, 0);  // evict M -> writeback
    peek("R10", 0, 0);
    step("R3", 1, 0, 2, 0, 0, 0, 1, 0);   // fill F
    peek("R3", 2, 5);
    step("R7", 0, 0, 2, 1, 0, 2, 0, 0);   // F -> S supply
    peek("R7", 2, 1);
    step("R5", 1, 1, 2, 0, 0, 0, 0, 0);   // S write -> RFO
    step("R8", 0, 0, 2, 1, 1, 2, 0, 0);   // snoop RFO from M
    peek("R8", 2, 0);
    step("R3", 1, 0, 3, 0, 0, 0, 1, 1);   // fill S
    peek("R3", 3, 1);
    step("R9", 0, 0, 3, 1, 2, 3, 0, 0);   // snoop upgrade -> I
    peek("R9", 3, 0);
    step("R10", 1, 2, 3, 0, 0, 0, 0, 0);  // evict I silent
    step("R5", 1, 1, 4, 0, 0, 0, 0, 0);   // I write -> RFO
    step("R12", 1, 3, 4, 1, 3, 4, 0, 0);  // no-op snoop suppresses, no change
    peek("R12", 4, 4);

    for (int k = 0; k < 4000; k++) begin
      step("R12", 1'($urandom), 2'($urandom), IW'($urandom), ($urandom % 4) == 0,
           2'($urandom), IW'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule